// File: doc/BRIEF.md
# Core Module System Control Register Bank

This block is the system control register file of a processor core module. It sits on a plain 32-bit register bus with byte addresses, separate read and write strobes and registered read data. It holds a fixed identifier and status word, two oscillator settings that only change while an unlock key is held, and a control word. The control word drives the boot-memory remap select and a board indicator, and it raises a one-cycle reset request. The bank also holds SDRAM and init configuration words, two flag words that are changed through separate set and clear addresses, and a free-running reference counter. A read-only window returns memory-module presence-detect bytes, and a small interrupt group offers separate IRQ and FIQ enables and a software interrupt.

The reference counter counts single-cycle `ref_tick` pulses supplied by the system from a fixed reference clock. It starts from zero at reset, so a read gives the number of ticks since reset. The `MEM_MB` parameter gives the fitted memory size. It sets the module-density byte of the presence-detect image and the size field of the SDRAM configuration reset value.

Top module: `cm_sysctl_bank`

## Requirements
- R1: A read of word index 0 returns 0x411A3001 and a read of index 4 returns 0x00100000. Indices 1, 6, 13, 15, 19, 21, 27 and 32 to 35 read as zero, and so does any other index with no register behind it.
- R2: A write to the key register (index 5) stores bits 15:0 of the write data. A read returns the stored value with bit 16 set when the stored value equals 0xA05F, and returns the stored value alone otherwise.
- R3: A write to the primary oscillator word (index 2) or the auxiliary oscillator word (index 7) updates it only while the stored key equals 0xA05F. Otherwise the write is dropped.
- R4: A write to the control word (index 3) stores only bits 0 and 2. Bit 3 of the write data raises `rst_req_o` for exactly the one cycle after the write. A read returns bits 0 and 2, with every other bit zero.
- R5: `remap_o` follows control bit 2 and `led_o` follows control bit 0. Both are zero after reset.
- R6: A write to index 12 ORs the data into the flag word, and a write to index 13 clears the bits that are set in the data. Indices 14 and 15 do the same for the second flag word. Reads of 12 and 14 return those words.
- R7: Byte offsets 0x100 to 0x17F return, in bits 7:0, the presence-detect byte at table entry offset>>2. Entry 64 is 0x80, entry 65 is 0x08 and entry 66 is 0x04. Entry 95 is the density code: 64 for MEM_MB of 256 or more, 32 for 128 or more, 16 for 64 or more, 4 for 32 or more, and 2 otherwise. All other entries are 0. Offsets 0x180 to 0x1FF read zero, and writes anywhere in the window have no effect.
- R8: Index 10 returns a 32-bit counter that is zero after reset and advances by one on each cycle in which `ref_tick` is high.
- R9: Reset values are 0x01000048 for the primary oscillator, 0x0007FEFF for the auxiliary oscillator and 0x00000112 for init. SDRAM is 0x00011122 ORed with a size field: 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise. SDRAM (index 8) and init (index 9) take any write.
- R10: The interrupt group works as follows.
  - Enables: a write to index 18 sets IRQ enable bits and a write to index 19 clears them. Indices 26 and 27 do the same for FIQ. Reads of 18 and 26 return the enables.
  - Software interrupt: a write to index 20 sets the level bit 0 when data bit 0 is 1, and a write to index 21 clears it when data bit 0 is 1. A read of 20 returns that level bit.
  - Status reads: indices 16 and 24 read level AND the IRQ or FIQ enable. Indices 17 and 25 read the raw level.
  - Outputs: `irq_o` and `fiq_o` are high while the matching masked status is nonzero.
- R11: A write to an index with no writable register behind it, or to an address above 0x1FF, changes no register and no output.
- R12: `rd_data` takes the selected value on the clock edge that samples `rd_en` high. It is zero after reset and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Byte address; bits 1:0 are ignored |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ref_tick | input | 1 | One-cycle reference clock tick |
| remap_o | output | 1 | High: boot flash overlay at address zero disabled |
| led_o | output | 1 | Board indicator drive |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Masked IRQ request |
| fiq_o | output | 1 | Masked FIQ request |

## Verification
The bench builds the bank with MEM_MB = 128 and AW = 12. The 128 MB setting reaches the non-default branch of the size decode, so the density byte reads 0x20 and the SDRAM reset value reads 0x0001112E instead of the plain default. With a 12-bit address, addresses above the presence-detect window (0x400) can be reached, which shows that decoding beyond the window returns zero and ignores writes.

// File: rtl/cm_sysctl_pkg.sv
// Package: shared constants, register index codes and the presence-detect
// image for the core module control bank. Assumes 32-bit registers.
package cm_sysctl_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned IDX_W     = 6;
    localparam int unsigned NUM_PAIRS = 4;

    localparam logic [15:0]       UNLOCK_KEY = 16'hA05F;
    localparam logic [DATA_W-1:0] ID_WORD    = 32'h411A3001;
    localparam logic [DATA_W-1:0] STAT_WORD  = 32'h00100000;
    localparam logic [DATA_W-1:0] OSC_RST    = 32'h01000048;
    localparam logic [DATA_W-1:0] AUXOSC_RST = 32'h0007FEFF;
    localparam logic [DATA_W-1:0] SDRAM_RST  = 32'h00011122;
    localparam logic [DATA_W-1:0] INIT_RST   = 32'h00000112;

    typedef enum logic [IDX_W-1:0] {
        IX_IDENT   = 6'd0,
        IX_OSC     = 6'd2,
        IX_CTRL    = 6'd3,
        IX_STATUS  = 6'd4,
        IX_KEY     = 6'd5,
        IX_AUXOSC  = 6'd7,
        IX_SDRAM   = 6'd8,
        IX_INIT    = 6'd9,
        IX_REFCNT  = 6'd10,
        IX_FLAG    = 6'd12,
        IX_NVFLAG  = 6'd14,
        IX_IRQ_MSK = 6'd16,
        IX_IRQ_RAW = 6'd17,
        IX_IRQ_EN  = 6'd18,
        IX_SW_SET  = 6'd20,
        IX_SW_CLR  = 6'd21,
        IX_FIQ_MSK = 6'd24,
        IX_FIQ_RAW = 6'd25,
        IX_FIQ_EN  = 6'd26
    } reg_idx_e;

    // Set address of each set/clear pair; the clear address is the next index.
    localparam logic [IDX_W-1:0] PAIR_SET_IDX [NUM_PAIRS] = '{6'd12, 6'd14, 6'd18, 6'd26};

    // Size field ORed into the SDRAM configuration reset value.
    function automatic logic [DATA_W-1:0] sdram_size_field(input int mb);
        if (mb >= 256)      return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    // Module density code held in the presence-detect image.
    function automatic logic [7:0] pd_density(input int mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

endpackage

// File: rtl/cm_setclr_reg.sv
// Module: one register word written through a set address and a clear
// address. Assumes set and clear strobes are never high together (they
// come from distinct decoded indices).
module cm_setclr_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Purpose: OR in on set, mask out on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));  // R6
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(wdata)) == '0));  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(q));  // R11

endmodule

// File: rtl/cm_ref_counter.sv
// Module: free-running reference counter. Assumes ref_tick is already a
// single-cycle enable in the clk domain; it starts from zero at reset.
module cm_ref_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count
);

    // Purpose: advance by one per tick, wrapping at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));  // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));  // R8

endmodule

// File: rtl/cm_pd_rom.sv
// Module: computed presence-detect image, one byte per table entry.
// Assumes the caller decodes the window; only entries 64..95 are visible.
module cm_pd_rom #(
    parameter int MEM_MB = 0
) (
    input  logic [6:0] entry,
    output logic [7:0] data
);
    import cm_sysctl_pkg::*;

    localparam logic [7:0] DENSITY = pd_density(MEM_MB);

    // Purpose: return the byte at the requested table entry.
    always_comb begin
        case (entry)
            7'd64:   data = 8'h80;
            7'd65:   data = 8'h08;
            7'd66:   data = 8'h04;
            7'd95:   data = DENSITY;
            default: data = 8'h00;
        endcase
    end

endmodule

// File: rtl/cm_sysctl_bank.sv
// Module: core module system control register bank (top). Decodes byte
// addresses to word indices, holds the keyed oscillator words, control,
// configuration, flag pairs, interrupt group and reference counter, and
// returns registered read data. Assumes single-cycle strobes, one access
// per cycle, AW of at least 10.
module cm_sysctl_bank #(
    parameter int unsigned AW     = 12,
    parameter int          MEM_MB = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW-1:0] addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        ref_tick,
    output logic        remap_o,
    output logic        led_o,
    output logic        rst_req_o,
    output logic        irq_o,
    output logic        fiq_o
);
    import cm_sysctl_pkg::*;

    localparam logic [DATA_W-1:0] SDRAM_INIT = SDRAM_RST | sdram_size_field(MEM_MB);

    logic [IDX_W-1:0]  idx;
    logic              in_regs, in_pd, wr_regs;
    logic [7:0]        pd_byte;
    logic              unused_addr_lsb;
    logic [15:0]       key_q;
    logic              unlocked;
    logic [DATA_W-1:0] osc_q, auxosc_q, sdram_q, init_q, refcnt;
    logic              led_q, remap_q, rst_req_q, sw_level;
    logic [DATA_W-1:0] pair_q [NUM_PAIRS];
    logic [DATA_W-1:0] flag_w, nvflag_w, irq_en, fiq_en, level_w;
    logic [DATA_W-1:0] rd_mux;

    assign idx             = addr[7:2];
    assign in_regs         = (addr[AW-1:8] == '0);
    assign in_pd           = (addr[AW-1:8] == 1) && !addr[7];
    assign wr_regs         = wr_en && in_regs;
    assign unused_addr_lsb = ^addr[1:0];
    assign unlocked        = (key_q == UNLOCK_KEY);

    cm_pd_rom #(.MEM_MB(MEM_MB)) u_pd (.entry(addr[8:2]), .data(pd_byte));

    cm_ref_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .count(refcnt)
    );

    // Set/clear pairs: flags, second flags, IRQ enables, FIQ enables.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        cm_setclr_reg #(.W(DATA_W)) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .set_we(wr_regs && (idx == PAIR_SET_IDX[g])),
            .clr_we(wr_regs && (idx == PAIR_SET_IDX[g] + 1'b1)),
            .wdata (wr_data),
            .q     (pair_q[g])
        );
    end
    assign flag_w   = pair_q[0];
    assign nvflag_w = pair_q[1];
    assign irq_en   = pair_q[2];
    assign fiq_en   = pair_q[3];
    assign level_w  = {{(DATA_W-1){1'b0}}, sw_level};

    // Purpose: key, keyed oscillator words and plain configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            osc_q    <= OSC_RST;
            auxosc_q <= AUXOSC_RST;
            sdram_q  <= SDRAM_INIT;
            init_q   <= INIT_RST;
        end else if (wr_regs) begin
            case (idx)
                IX_KEY:    key_q   <= wr_data[15:0];
                IX_OSC:    if (unlocked) osc_q    <= wr_data;
                IX_AUXOSC: if (unlocked) auxosc_q <= wr_data;
                IX_SDRAM:  sdram_q <= wr_data;
                IX_INIT:   init_q  <= wr_data;
                default:   ;
            endcase
        end
    end

    // Purpose: control bits and the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q     <= 1'b0;
            remap_q   <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= wr_regs && (idx == IX_CTRL) && wr_data[3];
            if (wr_regs && (idx == IX_CTRL)) begin
                led_q   <= wr_data[0];
                remap_q <= wr_data[2];
            end
        end
    end

    // Purpose: software interrupt level, bit 0 of the data only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         sw_level <= 1'b0;
        else if (wr_regs && idx == IX_SW_SET && wr_data[0]) sw_level <= 1'b1;
        else if (wr_regs && idx == IX_SW_CLR && wr_data[0]) sw_level <= 1'b0;
    end

    // Purpose: select the read value for the current address.
    always_comb begin
        rd_mux = '0;
        if (in_pd) begin
            rd_mux = {24'h0, pd_byte};
        end else if (in_regs) begin
            case (idx)
                IX_IDENT:   rd_mux = ID_WORD;
                IX_OSC:     rd_mux = osc_q;
                IX_CTRL:    rd_mux = {29'h0, remap_q, 1'b0, led_q};
                IX_STATUS:  rd_mux = STAT_WORD;
                IX_KEY:     rd_mux = {15'h0, unlocked, key_q};
                IX_AUXOSC:  rd_mux = auxosc_q;
                IX_SDRAM:   rd_mux = sdram_q;
                IX_INIT:    rd_mux = init_q;
                IX_REFCNT:  rd_mux = refcnt;
                IX_FLAG:    rd_mux = flag_w;
                IX_NVFLAG:  rd_mux = nvflag_w;
                IX_IRQ_MSK: rd_mux = level_w & irq_en;
                IX_IRQ_RAW: rd_mux = level_w;
                IX_IRQ_EN:  rd_mux = irq_en;
                IX_SW_SET:  rd_mux = level_w;
                IX_FIQ_MSK: rd_mux = level_w & fiq_en;
                IX_FIQ_RAW: rd_mux = level_w;
                IX_FIQ_EN:  rd_mux = fiq_en;
                default:    rd_mux = '0;
            endcase
        end
    end

    // Purpose: register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign remap_o   = remap_q;
    assign led_o     = led_q;
    assign rst_req_o = rst_req_q;
    assign irq_o     = sw_level && irq_en[0];
    assign fiq_o     = sw_level && fiq_en[0];

    AST_RSTREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(wr_en && in_regs && idx == IX_CTRL && wr_data[3]));  // R4
    AST_OSC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(osc_q) && $stable(auxosc_q)));  // R3
    AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && in_regs && idx == IX_CTRL) |=> ($stable(remap_o) && $stable(led_o)));  // R5
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));  // R12
    AST_OUT_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(irq_o) && $stable(fiq_o)));  // R10

endmodule

// File: tb/cm_sysctl_bank_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares each one on the negedge after the registering edge.
module cm_sysctl_bank_tb;

    localparam int unsigned AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, ref_tick = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        remap_o, led_o, rst_req_o, irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        due = 1'b0;
    logic        done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cm_sysctl_bank #(.AW(AW), .MEM_MB(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .ref_tick(ref_tick),
        .remap_o(remap_o), .led_o(led_o), .rst_req_o(rst_req_o),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: a read issued before the last posedge is due now.
    always @(posedge clk) due <= rd_en && rst_n;
    always @(negedge clk) begin
        if (due && exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick_n(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
            if (gap) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state of outputs (R5 R10 R12 R4)
        check("R5 remap reset", {31'h0, remap_o}, 32'h0);
        check("R5 led reset", {31'h0, led_o}, 32'h0);
        check("R4 rst_req reset", {31'h0, rst_req_o}, 32'h0);
        check("R10 irq/fiq reset", {30'h0, irq_o, fiq_o}, 32'h0);
        check("R12 rd_data reset", rd_data, 32'h0);

        // R1 constants and zero reads
        rd(12'h000, 32'h411A3001, "R1 ident");
        rd(12'h010, 32'h00100000, "R1 status");
        rd(12'h004, 32'h0, "R1 index 1");
        rd(12'h018, 32'h0, "R1 index 6");
        rd(12'h080, 32'h0, "R1 index 32");
        rd(12'h400, 32'h0, "R1 above window");

        // R9 reset values (128 MB build)
        rd(12'h008, 32'h01000048, "R9 osc reset");
        rd(12'h01C, 32'h0007FEFF, "R9 auxosc reset");
        rd(12'h020, 32'h0001112E, "R9 sdram reset");
        rd(12'h024, 32'h00000112, "R9 init reset");
        wr(12'h020, 32'h0BADF00D);
        wr(12'h024, 32'h00000777);
        rd(12'h020, 32'h0BADF00D, "R9 sdram write");
        rd(12'h024, 32'h00000777, "R9 init write");

        // R3 keyed writes dropped while locked
        rd(12'h014, 32'h0, "R2 key reset");
        wr(12'h008, 32'hDEADBEEF);
        wr(12'h01C, 32'hDEADBEEF);
        rd(12'h008, 32'h01000048, "R3 osc locked");
        rd(12'h01C, 32'h0007FEFF, "R3 auxosc locked");

        // R2 key, R3 writes accepted when open
        wr(12'h014, 32'h1234A05F);
        rd(12'h014, 32'h0001A05F, "R2 key open readback");
        wr(12'h008, 32'h12345678);
        wr(12'h01C, 32'hCAFEF00D);
        rd(12'h008, 32'h12345678, "R3 osc open");
        rd(12'h01C, 32'hCAFEF00D, "R3 auxosc open");
        wr(12'h014, 32'hFFFF1234);
        rd(12'h014, 32'h00001234, "R2 key low half only");
        wr(12'h008, 32'h0);
        rd(12'h008, 32'h12345678, "R3 osc relocked");

        // R4 R5 control word
        wr(12'h00C, 32'hFFFFFFFF);
        check("R4 rst_req pulse", {31'h0, rst_req_o}, 32'h1);
        check("R5 remap set", {31'h0, remap_o}, 32'h1);
        check("R5 led set", {31'h0, led_o}, 32'h1);
        @(negedge clk);
        check("R4 rst_req one cycle", {31'h0, rst_req_o}, 32'h0);
        rd(12'h00C, 32'h00000005, "R4 ctrl readback");
        wr(12'h00C, 32'h00000008);
        check("R4 rst_req second pulse", {31'h0, rst_req_o}, 32'h1);
        check("R5 remap cleared", {31'h0, remap_o}, 32'h0);
        rd(12'h00C, 32'h0, "R4 ctrl reset bit reads zero");
        wr(12'h00C, 32'h00000004);
        check("R4 no pulse without bit 3", {31'h0, rst_req_o}, 32'h0);
        check("R5 remap only", {30'h0, remap_o, led_o}, 32'h2);

        // R6 flag pairs
        wr(12'h030, 32'h0000F00F);
        wr(12'h030, 32'h00000100);
        rd(12'h030, 32'h0000F10F, "R6 flag set accumulates");
        wr(12'h034, 32'h0000000F);
        rd(12'h030, 32'h0000F100, "R6 flag clear");
        wr(12'h038, 32'hAAAA5555);
        wr(12'h03C, 32'h0000FFFF);
        rd(12'h038, 32'hAAAA0000, "R6 second flags");
        rd(12'h030, 32'h0000F100, "R6 flags independent");

        // R7 presence-detect window
        rd(12'h100, 32'h80, "R7 entry 64");
        rd(12'h104, 32'h08, "R7 entry 65");
        rd(12'h108, 32'h04, "R7 entry 66");
        rd(12'h10C, 32'h00, "R7 entry 67");
        rd(12'h17C, 32'h20, "R7 density 128MB");
        rd(12'h180, 32'h00, "R7 upper half zero");
        rd(12'h1FC, 32'h00, "R7 top zero");
        wr(12'h100, 32'hFFFFFFFF);
        rd(12'h100, 32'h80, "R7 window write ignored");

        // R8 reference counter
        rd(12'h028, 32'h0, "R8 counter idle");
        tick_n(3, 1'b1);
        tick_n(2, 1'b0);
        rd(12'h028, 32'h5, "R8 counter five ticks");

        // R10 interrupt group
        wr(12'h048, 32'h00000003);
        rd(12'h048, 32'h00000003, "R10 irq enable set");
        check("R10 no irq without level", {31'h0, irq_o}, 32'h0);
        wr(12'h050, 32'h00000002);
        rd(12'h050, 32'h0, "R10 soft set ignores bit1");
        wr(12'h050, 32'hFFFFFFFF);
        check("R10 irq raised", {31'h0, irq_o}, 32'h1);
        check("R10 fiq masked", {31'h0, fiq_o}, 32'h0);
        rd(12'h044, 32'h1, "R10 irq raw");
        rd(12'h040, 32'h1, "R10 irq masked status");
        rd(12'h060, 32'h0, "R10 fiq masked status");
        wr(12'h068, 32'h00000001);
        check("R10 fiq raised", {31'h0, fiq_o}, 32'h1);
        rd(12'h060, 32'h1, "R10 fiq status");
        wr(12'h04C, 32'h00000001);
        check("R10 irq enable cleared", {31'h0, irq_o}, 32'h0);
        rd(12'h048, 32'h2, "R10 irq enable after clear");
        wr(12'h054, 32'hFFFFFFFE);
        check("R10 soft clr ignores bit1", {31'h0, fiq_o}, 32'h1);
        wr(12'h054, 32'h00000001);
        check("R10 fiq dropped", {31'h0, fiq_o}, 32'h0);
        rd(12'h064, 32'h0, "R10 fiq raw cleared");

        // R11 writes with no register behind them
        wr(12'h058, 32'hFFFFFFFF);
        wr(12'h080, 32'hFFFFFFFF);
        wr(12'h430, 32'hFFFFFFFF);
        rd(12'h058, 32'h0, "R11 index 22 reads zero");
        rd(12'h030, 32'h0000F100, "R11 flags untouched");
        rd(12'h050, 32'h0, "R11 soft level untouched");

        // R12 hold while no read
        rd(12'h000, 32'h411A3001, "R12 last read");
        repeat (3) @(negedge clk);
        check("R12 rd_data holds", rd_data, 32'h411A3001);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard not drained actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule